// File: doc/BRIEF.md
# Worker Program Sequencer

This block is one worker of a data-parallel array. While idle it takes a dispatch that carries a two-dimensional work coordinate (i, j) and a conditional value. It then raises busy, clears its program counter and steps through the program. For each instruction it issues one fetch, waits for the instruction word, and carries out that instruction's memory request, if there is one. After the instruction at the configured last address has completed, it drops busy and will take another dispatch.

Each memory request carries an access type and an (x, y) index pair. How the pair is formed depends on the type. Output writes are always addressed by the dispatched coordinate. When conditional output is enabled, a write is first offered to an external pass/fail test, and the write is issued only if that test passes. Instruction semantics and data values are outside this block. An instruction is reduced to a small decoded word, {kind[2:0], sel, fieldA[IDXW-1:0], fieldB[IDXW-1:0]}, with kind in the most significant bits.

Top module: `worker_seq`

## Requirements
- R1: `dispReady` is 1 exactly when the block is idle. A dispatch taken on a clock edge makes `busy` 1 after that edge, and the first request that follows is an instruction fetch of address 0.
- R2: While `busy` is 1, a dispatch is not taken (`dispReady` is 0). A dispatch offered during a run does not change the coordinate used by that run's output writes.
- R3: The program counter moves on by one only after the current instruction has completed, so fetch addresses run 0, 1, … with no gap or repeat.
- R4: After the instruction at address `endPc` completes, `busy` returns to 0 and `dispReady` to 1. With `endPc` = 0, exactly one instruction runs.
- R5: An instruction fetch has type 0 and index (pc, 0). `memRspValid` returns its instruction word.
- R6: Kinds 1, 2 and 3 issue a float, integer or boolean constant read, with the request type equal to the kind, and index (fieldA, 0).
- R7: Kind 4 issues an input read of type 4 with index (fieldA, fieldB).
- R8: Kind 5 is an output write of type 5. Its index is the dispatched (i, j) and `memReqId` is fieldA.
- R9: With `condEnable` = 1, kind 5 first raises `condReqValid` with the conditional value and (i, j), and holds it until `condRspValid`. The write is issued only if `condRspPass` is 1. Otherwise the instruction completes with no write.
- R10: The conditional value is fieldB when sel = 1, and the dispatched value when sel = 0.
- R11: With `condEnable` = 0, no conditional request is raised and every kind-5 write is issued.
- R12: A request held while `memReqReady` is 0 keeps its type, index and identifier unchanged.
- R13: Kinds 0, 6 and 7 complete after their fetch and issue no data request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch offered |
| dispReady | output | 1 | Dispatch can be taken (idle) |
| dispI | input | IDXW | Work coordinate i |
| dispJ | input | IDXW | Work coordinate j |
| dispCond | input | IDXW | Dispatched conditional value |
| endPc | input | IDXW | Address of the last instruction |
| condEnable | input | 1 | Conditional output enabled |
| busy | output | 1 | A program run is in progress |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqType | output | 3 | Access type 0..5 |
| memReqX | output | IDXW | Index x |
| memReqY | output | IDXW | Index y |
| memReqId | output | IDXW | Output identifier (writes only) |
| memRspValid | input | 1 | Instruction word returned |
| memRspData | input | 4+2*IDXW | Instruction word |
| condReqValid | output | 1 | Conditional test requested |
| condReqValue | output | IDXW | Value to test |
| condReqI | output | IDXW | Coordinate i for the test |
| condReqJ | output | IDXW | Coordinate j for the test |
| condRspValid | input | 1 | Test answer valid |
| condRspPass | input | 1 | Test passed |

## Verification
The hardest case to reach is a dispatch offered in the middle of a run. If the block took it by mistake, the only visible effect would be a changed coordinate on a later output write. The bench therefore offers a second dispatch with different values while a long program stalls on a memory that refuses every third cycle. It places the output write after the dispatch window closes. With conditional output enabled, pass and fail answers, and immediate and dispatched conditional values, are mixed within one program. This shows which writes must appear and which must not.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  typedef enum logic [2:0] {
    REQ_FETCH  = 3'd0,
    REQ_FCONST = 3'd1,
    REQ_ICONST = 3'd2,
    REQ_BCONST = 3'd3,
    REQ_INPUT  = 3'd4,
    REQ_OUTPUT = 3'd5
  } reqKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDisp;
    logic clrPc;
    logic incPc;
    logic loadInstr;
    logic selFetch;
  } strobes_t;

endpackage

// File: rtl/wseq_dp.sv
module wseq_dp
  import wseq_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [IDXW-1:0]       dispI,
  input  logic [IDXW-1:0]       dispJ,
  input  logic [IDXW-1:0]       dispCond,
  input  logic [IDXW-1:0]       endPc,
  input  logic [4+2*IDXW-1:0]   memRspData,
  output logic [2:0]            curKind,
  output logic                  atEnd,
  output logic [2:0]            memReqType,
  output logic [IDXW-1:0]       memReqX,
  output logic [IDXW-1:0]       memReqY,
  output logic [IDXW-1:0]       memReqId,
  output logic [IDXW-1:0]       condReqValue,
  output logic [IDXW-1:0]       condReqI,
  output logic [IDXW-1:0]       condReqJ
);

  localparam int IW = 4 + 2*IDXW;

  logic [IDXW-1:0] idxI, idxJ, condVal, pc;
  logic [IW-1:0]   instr;
  logic            fSel;
  logic [IDXW-1:0] fA, fB;

  assign curKind = instr[IW-1 -: 3];
  assign fSel    = instr[2*IDXW];
  assign fA      = instr[2*IDXW-1 -: IDXW];
  assign fB      = instr[IDXW-1:0];
  assign atEnd   = (pc == endPc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxI    <= '0;
      idxJ    <= '0;
      condVal <= '0;
      pc      <= '0;
      instr   <= '0;
    end else begin
      if (strb.loadDisp) begin
        idxI    <= dispI;
        idxJ    <= dispJ;
        condVal <= dispCond;
      end
      if (strb.clrPc)          pc <= '0;
      else if (strb.incPc)     pc <= pc + 1'b1;
      if (strb.loadInstr)      instr <= memRspData;
    end
  end

  always_comb begin
    memReqType = REQ_FETCH;
    memReqX    = '0;
    memReqY    = '0;
    memReqId   = '0;
    if (strb.selFetch) begin
      memReqX = pc;
    end else begin
      memReqType = curKind;
      case (curKind)
        REQ_FCONST, REQ_ICONST, REQ_BCONST: memReqX = fA;
        REQ_INPUT: begin
          memReqX = fA;
          memReqY = fB;
        end
        REQ_OUTPUT: begin
          memReqX  = idxI;
          memReqY  = idxJ;
          memReqId = fA;
        end
        default: memReqType = REQ_FETCH;
      endcase
    end
  end

  assign condReqValue = fSel ? fB : condVal;
  assign condReqI     = idxI;
  assign condReqJ     = idxJ;

endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dispValid,
  output logic       dispReady,
  output logic       busy,
  output logic       memReqValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       condEnable,
  output logic       condReqValid,
  input  logic       condRspValid,
  input  logic       condRspPass,
  input  logic [2:0] curKind,
  input  logic       atEnd,
  output strobes_t   strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_DECODE, S_DATA, S_COND, S_DONE
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      S_IDLE: if (dispValid) begin
        strb.loadDisp = 1'b1;
        strb.clrPc    = 1'b1;
        nextState     = S_FETCH;
      end
      S_FETCH: begin
        strb.selFetch = 1'b1;
        if (memReqReady) nextState = S_WAIT;
      end
      S_WAIT: if (memRspValid) begin
        strb.loadInstr = 1'b1;
        nextState      = S_DECODE;
      end
      S_DECODE: begin
        case (curKind)
          REQ_FCONST, REQ_ICONST, REQ_BCONST, REQ_INPUT: nextState = S_DATA;
          REQ_OUTPUT: nextState = condEnable ? S_COND : S_DATA;
          default:    nextState = S_DONE;
        endcase
      end
      S_DATA: if (memReqReady) nextState = S_DONE;
      S_COND: if (condRspValid) nextState = condRspPass ? S_DATA : S_DONE;
      S_DONE: begin
        if (atEnd) nextState = S_IDLE;
        else begin
          strb.incPc = 1'b1;
          nextState  = S_FETCH;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign dispReady    = (state == S_IDLE);
  assign busy         = (state != S_IDLE);
  assign memReqValid  = (state == S_FETCH) || (state == S_DATA);
  assign condReqValid = (state == S_COND);

endmodule

// File: rtl/worker_seq.sv
module worker_seq
  import wseq_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dispValid,
  output logic                dispReady,
  input  logic [IDXW-1:0]     dispI,
  input  logic [IDXW-1:0]     dispJ,
  input  logic [IDXW-1:0]     dispCond,
  input  logic [IDXW-1:0]     endPc,
  input  logic                condEnable,
  output logic                busy,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [2:0]          memReqType,
  output logic [IDXW-1:0]     memReqX,
  output logic [IDXW-1:0]     memReqY,
  output logic [IDXW-1:0]     memReqId,
  input  logic                memRspValid,
  input  logic [4+2*IDXW-1:0] memRspData,
  output logic                condReqValid,
  output logic [IDXW-1:0]     condReqValue,
  output logic [IDXW-1:0]     condReqI,
  output logic [IDXW-1:0]     condReqJ,
  input  logic                condRspValid,
  input  logic                condRspPass
);

  strobes_t   strb;
  logic [2:0] curKind;
  logic       atEnd;

  wseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispReady(dispReady), .busy(busy),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .condEnable(condEnable),
    .condReqValid(condReqValid), .condRspValid(condRspValid),
    .condRspPass(condRspPass), .curKind(curKind), .atEnd(atEnd),
    .strb(strb)
  );

  wseq_dp #(.IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dispI(dispI), .dispJ(dispJ), .dispCond(dispCond), .endPc(endPc),
    .memRspData(memRspData), .curKind(curKind), .atEnd(atEnd),
    .memReqType(memReqType), .memReqX(memReqX), .memReqY(memReqY),
    .memReqId(memReqId), .condReqValue(condReqValue),
    .condReqI(condReqI), .condReqJ(condReqJ)
  );

endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            dispValid,
  input logic            dispReady,
  input logic            busy,
  input logic            condEnable,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [2:0]      memReqType,
  input logic [IDXW-1:0] memReqX,
  input logic [IDXW-1:0] memReqY,
  input logic [IDXW-1:0] memReqId,
  input logic            condReqValid
);

  // R1
  dispatch_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> busy && memReqValid && memReqType == 3'd0 && memReqX == '0);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqType) &&
      $stable(memReqX) && $stable(memReqY) && $stable(memReqId));

  // R5
  fetch_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqType == 3'd0 |-> memReqY == '0);

  // R11
  cond_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !condEnable |-> !condReqValid);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !condReqValid);

  // R9
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    condReqValid |-> !memReqValid);

endmodule

bind worker_seq wseq_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .busy(busy), .condEnable(condEnable), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqType(memReqType), .memReqX(memReqX),
  .memReqY(memReqY), .memReqId(memReqId), .condReqValid(condReqValid)
);

// File: tb/test_worker_seq.sv
`timescale 1ns/1ps
module test_worker_seq;

  localparam int IDXW = 8;
  localparam int IW   = 4 + 2*IDXW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic dispReady, busy;
  logic [IDXW-1:0] dispI = '0, dispJ = '0, dispCond = '0, endPc = '0;
  logic condEnable = 1'b0;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [2:0] memReqType;
  logic [IDXW-1:0] memReqX, memReqY, memReqId;
  logic memRspValid = 1'b0;
  logic [IW-1:0] memRspData = '0;
  logic condReqValid;
  logic [IDXW-1:0] condReqValue, condReqI, condReqJ;
  logic condRspValid = 1'b0;
  logic condRspPass = 1'b0;

  always #2.5 clk = ~clk;

  worker_seq #(.IDXW(IDXW)) i_worker_seq (.*);

  typedef struct { logic [2:0] t; logic [IDXW-1:0] x, y, id; } memExp_t;
  typedef struct { logic [IDXW-1:0] v, i, j; } condExp_t;

  memExp_t  memQ[$];
  condExp_t condQ[$];
  logic [IW-1:0] prog [16];

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;
  bit pendF = 0;
  logic [IDXW-1:0] pendAddr = '0;
  bit condAns = 0;

  function automatic logic [IW-1:0] mk(input logic [2:0] k, input logic s,
                                       input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
    return {k, s, a, b};
  endfunction

  function automatic bit condPass(input logic [IDXW-1:0] v, input logic [IDXW-1:0] i,
                                  input logic [IDXW-1:0] j);
    return ^(v ^ i ^ j) == 1'b0;
  endfunction

  function automatic string tagOf(input logic [2:0] t);
    case (t)
      3'd0: return "R5/R3";
      3'd1, 3'd2, 3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // memory and conditional-test models plus monitor
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      memReqReady = (cyc % 3) != 0;
      memRspValid = pendF;
      memRspData  = prog[pendAddr[3:0]];
      pendF = 0;
      if (memReqValid && memReqReady) begin
        if (memQ.size() == 0) begin
          check(0, tagOf(memReqType), $sformatf("unexpected request t=%0d x=%0d y=%0d id=%0d, expected none",
                memReqType, memReqX, memReqY, memReqId));
        end else begin
          memExp_t e;
          e = memQ.pop_front();
          check(e.t == memReqType && e.x == memReqX && e.y == memReqY && e.id == memReqId,
                tagOf(e.t), $sformatf("request actual t=%0d x=%0d y=%0d id=%0d expected t=%0d x=%0d y=%0d id=%0d",
                memReqType, memReqX, memReqY, memReqId, e.t, e.x, e.y, e.id));
        end
        if (memReqType == 3'd0) begin
          pendF = 1;
          pendAddr = memReqX;
        end
      end
      condRspValid = 0;
      if (condReqValid && !condAns) begin
        if (condQ.size() == 0) begin
          check(0, "R9", $sformatf("unexpected cond request v=%0d, expected none", condReqValue));
        end else begin
          condExp_t c;
          c = condQ.pop_front();
          check(c.v == condReqValue && c.i == condReqI && c.j == condReqJ, "R9/R10",
                $sformatf("cond actual v=%0d i=%0d j=%0d expected v=%0d i=%0d j=%0d",
                condReqValue, condReqI, condReqJ, c.v, c.i, c.j));
        end
        condRspValid = 1;
        condRspPass  = condPass(condReqValue, condReqI, condReqJ);
        condAns = 1;
      end else begin
        condAns = 0;
      end
    end
  end

  // driver: builds expectations, dispatches, optionally intrudes, waits for idle
  task automatic runProg(input logic [IDXW-1:0] i, input logic [IDXW-1:0] j,
                         input logic [IDXW-1:0] c, input bit ce,
                         input logic [IDXW-1:0] last, input bit intrude);
    for (int p = 0; p <= int'(last); p++) begin
      logic [2:0] k;
      logic s;
      logic [IDXW-1:0] a, b, v;
      memExp_t e;
      {k, s, a, b} = prog[p];
      e = '{3'd0, IDXW'(p), '0, '0};
      memQ.push_back(e);
      case (k)
        3'd1, 3'd2, 3'd3: memQ.push_back('{k, a, '0, '0});
        3'd4: memQ.push_back('{k, a, b, '0});
        3'd5: begin
          v = s ? b : c;
          if (ce) begin
            condQ.push_back('{v, i, j});
            if (condPass(v, i, j)) memQ.push_back('{k, i, j, a});
          end else begin
            memQ.push_back('{k, i, j, a});
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    condEnable = ce; endPc = last;
    dispI = i; dispJ = j; dispCond = c; dispValid = 1;
    @(negedge clk);
    dispValid = 0;
    check(busy == 1'b1 && dispReady == 1'b0, "R1",
          $sformatf("after dispatch busy=%0d ready=%0d expected 1 0", busy, dispReady));
    if (intrude) begin
      dispI = i + 8'd77; dispJ = j + 8'd33; dispCond = c + 8'd1; dispValid = 1;
      for (int n = 0; n < 3; n++) begin
        @(negedge clk);
        check(dispReady == 1'b0, "R2", $sformatf("dispReady=%0d while busy expected 0", dispReady));
      end
      dispValid = 0;
    end
    while (busy) @(negedge clk);
    check(dispReady == 1'b1, "R4", $sformatf("dispReady=%0d after run expected 1", dispReady));
    check(memQ.size() == 0, "R4", $sformatf("pending requests %0d expected 0", memQ.size()));
    check(condQ.size() == 0, "R9", $sformatf("pending cond tests %0d expected 0", condQ.size()));
    memQ.delete();
    condQ.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 16; p++) prog[p] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(dispReady == 1 && busy == 0 && memReqValid == 0 && condReqValid == 0, "R1",
          $sformatf("reset ready=%0d busy=%0d req=%0d cond=%0d expected 1 0 0 0",
          dispReady, busy, memReqValid, condReqValid));

    // every kind, conditional output off (R6 R7 R8 R11 R13)
    prog[0] = mk(3'd1, 0, 8'd12, 8'd99);
    prog[1] = mk(3'd2, 0, 8'd34, 8'd5);
    prog[2] = mk(3'd3, 0, 8'd56, 8'd7);
    prog[3] = mk(3'd4, 0, 8'd21, 8'd43);
    prog[4] = mk(3'd0, 0, 8'd1, 8'd2);
    prog[5] = mk(3'd5, 0, 8'd9, 8'd0);
    prog[6] = mk(3'd7, 1, 8'd3, 8'd3);
    prog[7] = mk(3'd5, 1, 8'd4, 8'd6);
    runProg(8'd5, 8'd10, 8'd3, 0, 8'd7, 0);

    // conditional output on (R9 R10): choose values giving pass and fail
    prog[5] = mk(3'd5, 0, 8'd9, 8'd0);   // dispatched value
    prog[7] = mk(3'd5, 1, 8'd4, 8'd1);   // immediate 1
    prog[8] = mk(3'd5, 1, 8'd6, 8'd3);   // immediate 3
    runProg(8'd5, 8'd10, 8'd3, 1, 8'd8, 0);
    runProg(8'd4, 8'd10, 8'd3, 1, 8'd8, 0);

    // single instruction run (R4)
    prog[0] = mk(3'd4, 0, 8'd8, 8'd9);
    runProg(8'd1, 8'd2, 8'd0, 0, 8'd0, 0);

    // dispatch while busy is ignored (R2)
    prog[0] = mk(3'd0, 0, 8'd0, 8'd0);
    prog[1] = mk(3'd2, 0, 8'd11, 8'd0);
    prog[2] = mk(3'd6, 0, 8'd0, 8'd0);
    prog[3] = mk(3'd3, 0, 8'd13, 8'd0);
    prog[4] = mk(3'd5, 0, 8'd15, 8'd0);
    runProg(8'd20, 8'd30, 8'd2, 0, 8'd4, 1);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule